// File: doc/BRIEF.md
# Display Adapter I/O Port Decoder

This block sits between a host I/O bus and the register file of a display adapter that can run with either a monochrome or a colour port layout. It decodes every host read and write against a small set of fixed ports. It holds three registers: the general output-control register, a two-bit monochrome feature-enable register, and the monochrome mode register. From these it generates chip selects for the CRTC index and data ports and for the input-status port, but only at the base that is currently active.

Bit 0 of the output-control register chooses the base. When it is set, the CRTC and status ports live at 3D4, 3D5 and 3DA. When it is clear, they live at 3B4, 3B5 and 3BA, and the other set of addresses is ignored. A status read returns a retrace code and also tells the attribute controller to reset its index/data toggle. A write to the monochrome mode port can switch between graphics and text, but only while the feature-enable register allows it. Such a switch also moves the CRTC ports to the monochrome base.

Reads are combinational: read data is valid in the same cycle the read strobe is high. Register writes take effect on the clock edge on which the write strobe is sampled high.

Top module: `dio_port_hub`

## Requirements
- R1: When output-control bit 0 is 1, a read or write at 3D4, 3D5 or 3DA raises the CRTC index, CRTC data or status select. Accesses at 3B4, 3B5 and 3BA raise no select, and reads there return 0xFF.
- R2: When output-control bit 0 is 0, the selects respond at 3B4, 3B5 and 3BA only, and 3D4, 3D5 and 3DA raise nothing.
- R3: The output-control register is written at 3C2 and read at 3CC, resets to 0x01, and drives `color_base` from its bit 0.
- R4: A read of the status port at the active base pulses `attr_ff_clr` in that same cycle. A read at the inactive status address does not.
- R5: During vertical retrace, a status read returns 0x81 when the graphics selection is set and bit 0 of the output-control register is 0. Otherwise it returns 0x09.
- R6: Outside retrace, a status read returns 0x00 or 0x01 in turn, starting at 0x00 after reset. Each active status read outside retrace advances this toggle, and reads during retrace leave it alone.
- R7: A write at 3BF stores data bits 1:0 as the feature-enable bits, which reset to 0. A read at 3BF returns 0xFF.
- R8: A write at 3B8 always updates `mono_mode`. Only when feature-enable bit 0 is 1 does data bit 1 set `gfx_mode` (1 = graphics, 0 = text).
- R9: `disp_page` equals bit 7 of the mode register while feature-enable bit 1 is 1, and is 0 otherwise.
- R10: A write at 3B8 while feature-enable bit 0 is 1 clears output-control bit 0 and leaves its other bits unchanged.
- R11: The read data is 0xFF whenever no read is strobed, and also for reads of write-only or unmapped ports. CRTC index and data reads pass `crtc_rdata` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| vretrace | input | 1 | Vertical retrace in progress |
| crtc_rdata | input | 8 | Read data returned by the CRTC |
| crtc_idx_sel | output | 1 | CRTC index port select |
| crtc_dat_sel | output | 1 | CRTC data port select |
| stat_sel | output | 1 | Input-status port select |
| attr_ff_clr | output | 1 | Reset pulse for the attribute index/data toggle |
| color_base | output | 1 | Colour port layout active |
| gfx_mode | output | 1 | Monochrome graphics selected |
| disp_page | output | 1 | Displayed page |
| mono_mode | output | 8 | Last value written to the mode port |

## Verification
Several properties are checked on every cycle. Select pulses may only appear at the address of the current base. The clear pulse must coincide with a status read. Idle read data must be 0xFF. A gated mode write must leave the graphics selection unchanged, and an enabled one must force the monochrome base. Each non-retrace status read must flip the display-enable toggle. Other behaviour can only be shown by the bench's scenarios: the base moving after a write to the output-control register, the exact retrace codes for each base and mode combination, toggle order across interleaved retrace reads, and page selection under each enable setting.

// File: rtl/dio_pkg.sv
package dio_pkg;

   typedef enum logic [3:0] {
      HIT_NONE,
      HIT_CRTC_IDX,
      HIT_CRTC_DAT,
      HIT_STATUS,
      HIT_CTRL_WR,
      HIT_CTRL_RD,
      HIT_MONO_MODE,
      HIT_MONO_CFG
   } port_hit_e;

   localparam logic [15:0] MONO_BASE  = 16'h03B0;
   localparam logic [15:0] COLOR_BASE = 16'h03D0;
   localparam logic [15:0] OFS_IDX    = 16'h0004;
   localparam logic [15:0] OFS_DAT    = 16'h0005;
   localparam logic [15:0] OFS_STAT   = 16'h000A;
   localparam logic [15:0] CTRL_WR    = 16'h03C2;
   localparam logic [15:0] CTRL_RD    = 16'h03CC;
   localparam logic [15:0] MONO_MODE  = 16'h03B8;
   localparam logic [15:0] MONO_CFG   = 16'h03BF;

   localparam logic [7:0] RETR_MONO_GFX = 8'h81;
   localparam logic [7:0] RETR_COLOR    = 8'h09;
   localparam logic [7:0] OPEN_BUS      = 8'hFF;

endpackage

// File: rtl/dio_decode.sv
module dio_decode
   import dio_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              color_sel,
   output port_hit_e         hit
);
   localparam int NCRT = 3;
   localparam logic [15:0] CRT_OFS [NCRT] = '{OFS_IDX, OFS_DAT, OFS_STAT};

   initial begin
      assert (ADDR_W >= 10 && ADDR_W <= 32)
         else $error("dio_decode: ADDR_W must lie in 10..32");
   end

   logic [15:0]     base;
   logic [NCRT-1:0] crt_hit;

   assign base = color_sel ? COLOR_BASE : MONO_BASE;

   for (genvar g = 0; g < NCRT; g++) begin : g_crt
      assign crt_hit[g] = (addr == ADDR_W'(base + CRT_OFS[g]));
   end

   always_comb begin
      hit = HIT_NONE;
      if (crt_hit[0])                       hit = HIT_CRTC_IDX;
      else if (crt_hit[1])                  hit = HIT_CRTC_DAT;
      else if (crt_hit[2])                  hit = HIT_STATUS;
      else if (addr == ADDR_W'(CTRL_WR))    hit = HIT_CTRL_WR;
      else if (addr == ADDR_W'(CTRL_RD))    hit = HIT_CTRL_RD;
      else if (addr == ADDR_W'(MONO_MODE))  hit = HIT_MONO_MODE;
      else if (addr == ADDR_W'(MONO_CFG))   hit = HIT_MONO_CFG;
   end

endmodule

// File: rtl/dio_regs.sv
module dio_regs #(
   parameter logic [7:0] CTRL_RST = 8'h01,
   parameter int         CFG_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_cfg,
   input  logic             wr_mode,
   input  logic [7:0]       wdata,
   output logic [7:0]       ctrl_q,
   output logic [CFG_W-1:0] cfg_q,
   output logic [7:0]       mode_q,
   output logic             gfx_q
);
   initial begin
      assert (CFG_W >= 2 && CFG_W <= 8)
         else $error("dio_regs: CFG_W must lie in 2..8");
   end

   logic mode_switch;
   assign mode_switch = wr_mode & cfg_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         cfg_q  <= '0;
         mode_q <= '0;
         gfx_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata;
         if (wr_cfg)  cfg_q  <= wdata[CFG_W-1:0];
         if (wr_mode) mode_q <= wdata;
         if (mode_switch) begin
            gfx_q     <= wdata[1];
            ctrl_q[0] <= 1'b0;
         end
      end
   end

   p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && !cfg_q[0]) |=> $stable(gfx_q));

   p_mode_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode |=> (mode_q == $past(wdata)));

   p_force_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && cfg_q[0]) |=> !ctrl_q[0]);

   p_cfg_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> (cfg_q == $past(wdata[CFG_W-1:0])));

endmodule

// File: rtl/dio_status.sv
module dio_status
   import dio_pkg::*;
#(
   parameter bit DE_TOGGLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_stat,
   input  logic       vretrace,
   input  logic       gfx_sel,
   input  logic       color_sel,
   output logic [7:0] stat_val
);
   logic de_bit;

   if (DE_TOGGLE) begin : g_toggle
      logic tog_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                   tog_q <= 1'b0;
         else if (rd_stat && !vretrace) tog_q <= ~tog_q;
      end
      assign de_bit = tog_q;

      p_de_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stat && !vretrace) |=> (tog_q != $past(tog_q)));

      p_retr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stat && vretrace) |=> $stable(tog_q));
   end else begin : g_fixed
      assign de_bit = 1'b0;
   end

   always_comb begin
      if (vretrace)
         stat_val = (gfx_sel && !color_sel) ? RETR_MONO_GFX : RETR_COLOR;
      else
         stat_val = {7'b0, de_bit};
   end

endmodule

// File: rtl/dio_port_hub.sv
module dio_port_hub
   import dio_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter logic [7:0] CTRL_RST  = 8'h01,
   parameter bit         DE_TOGGLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              vretrace,
   input  logic [7:0]        crtc_rdata,
   output logic              crtc_idx_sel,
   output logic              crtc_dat_sel,
   output logic              stat_sel,
   output logic              attr_ff_clr,
   output logic              color_base,
   output logic              gfx_mode,
   output logic              disp_page,
   output logic [7:0]        mono_mode
);
   localparam int CFG_W = 2;

   port_hit_e        hit;
   logic [7:0]       ctrl_q;
   logic [CFG_W-1:0] cfg_q;
   logic [7:0]       stat_val;
   logic             access;

   assign access = io_rd | io_wr;

   dio_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr      (io_addr),
      .color_sel (ctrl_q[0]),
      .hit       (hit)
   );

   dio_regs #(.CTRL_RST(CTRL_RST), .CFG_W(CFG_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (io_wr && hit == HIT_CTRL_WR),
      .wr_cfg  (io_wr && hit == HIT_MONO_CFG),
      .wr_mode (io_wr && hit == HIT_MONO_MODE),
      .wdata   (io_wdata),
      .ctrl_q  (ctrl_q),
      .cfg_q   (cfg_q),
      .mode_q  (mono_mode),
      .gfx_q   (gfx_mode)
   );

   dio_status #(.DE_TOGGLE(DE_TOGGLE)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_stat   (io_rd && hit == HIT_STATUS),
      .vretrace  (vretrace),
      .gfx_sel   (gfx_mode),
      .color_sel (ctrl_q[0]),
      .stat_val  (stat_val)
   );

   assign crtc_idx_sel = access && hit == HIT_CRTC_IDX;
   assign crtc_dat_sel = access && hit == HIT_CRTC_DAT;
   assign stat_sel     = access && hit == HIT_STATUS;
   assign attr_ff_clr  = io_rd  && hit == HIT_STATUS;
   assign color_base   = ctrl_q[0];
   assign disp_page    = cfg_q[1] & mono_mode[7];

   always_comb begin
      io_rdata = OPEN_BUS;
      if (io_rd) begin
         unique case (hit)
            HIT_CRTC_IDX, HIT_CRTC_DAT: io_rdata = crtc_rdata;
            HIT_STATUS:                 io_rdata = stat_val;
            HIT_CTRL_RD:                io_rdata = ctrl_q;
            default:                    io_rdata = OPEN_BUS;
         endcase
      end
   end

   p_color_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((crtc_idx_sel || crtc_dat_sel || stat_sel) && color_base)
         |-> (io_addr[ADDR_W-1:4] == ADDR_W'(COLOR_BASE) >> 4));

   p_mono_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((crtc_idx_sel || crtc_dat_sel || stat_sel) && !color_base)
         |-> (io_addr[ADDR_W-1:4] == ADDR_W'(MONO_BASE) >> 4));

   p_attr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      attr_ff_clr |-> (stat_sel && io_rd));

   p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == OPEN_BUS));

   p_page_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      disp_page |-> mono_mode[7]);

   p_one_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({crtc_idx_sel, crtc_dat_sel, stat_sel}));

endmodule

// File: tb/dio_port_hub_bench.sv
module dio_port_hub_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] io_addr;
   logic        io_wr, io_rd, vretrace;
   logic [7:0]  io_wdata, io_rdata, crtc_rdata, mono_mode;
   logic        crtc_idx_sel, crtc_dat_sel, stat_sel, attr_ff_clr;
   logic        color_base, gfx_mode, disp_page;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_ctrl;
   logic [1:0] m_cfg;
   logic [7:0] m_mode;
   logic       m_gfx;
   logic       m_tog;

   always #5 clk = ~clk;

   dio_port_hub u_dio_port_hub (
      .clk          (clk),
      .rst_n        (rst_n),
      .io_addr      (io_addr),
      .io_wr        (io_wr),
      .io_rd        (io_rd),
      .io_wdata     (io_wdata),
      .io_rdata     (io_rdata),
      .vretrace     (vretrace),
      .crtc_rdata   (crtc_rdata),
      .crtc_idx_sel (crtc_idx_sel),
      .crtc_dat_sel (crtc_dat_sel),
      .stat_sel     (stat_sel),
      .attr_ff_clr  (attr_ff_clr),
      .color_base   (color_base),
      .gfx_mode     (gfx_mode),
      .disp_page    (disp_page),
      .mono_mode    (mono_mode)
   );

   task automatic chk(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input logic [15:0] a, input logic w,
                      input logic r, input logic [7:0] d, input logic vr);
      logic [15:0] base;
      logic [7:0]  e_rd, e_stat;
      logic        e_idx, e_dat, e_st;
      @(negedge clk);
      io_addr = a; io_wr = w; io_rd = r; io_wdata = d; vretrace = vr;
      #2;
      base   = m_ctrl[0] ? 16'h03D0 : 16'h03B0;
      e_idx  = (r | w) && a == base + 16'h4;
      e_dat  = (r | w) && a == base + 16'h5;
      e_st   = (r | w) && a == base + 16'hA;
      e_stat = vr ? ((m_gfx && !m_ctrl[0]) ? 8'h81 : 8'h09) : {7'b0, m_tog};
      e_rd   = 8'hFF;
      if (r) begin
         if (e_idx || e_dat)        e_rd = crtc_rdata;
         else if (e_st)             e_rd = e_stat;
         else if (a == 16'h03CC)    e_rd = m_ctrl;
      end
      chk(tag, "rdata",    io_rdata,            e_rd);
      chk(tag, "idx_sel",  {7'b0, crtc_idx_sel}, {7'b0, e_idx});
      chk(tag, "dat_sel",  {7'b0, crtc_dat_sel}, {7'b0, e_dat});
      chk(tag, "stat_sel", {7'b0, stat_sel},     {7'b0, e_st});
      chk(tag, "attr_clr", {7'b0, attr_ff_clr},  {7'b0, e_st && r});
      chk(tag, "color",    {7'b0, color_base},   {7'b0, m_ctrl[0]});
      chk(tag, "gfx",      {7'b0, gfx_mode},     {7'b0, m_gfx});
      chk(tag, "page",     {7'b0, disp_page},    {7'b0, m_cfg[1] & m_mode[7]});
      chk(tag, "mode",     mono_mode,            m_mode);
      @(posedge clk);
      #1;
      if (r && e_st && !vr) m_tog = ~m_tog;
      if (w) begin
         if (a == 16'h03C2) m_ctrl = d;
         if (a == 16'h03BF) m_cfg = d[1:0];
         if (a == 16'h03B8) begin
            m_mode = d;
            if (m_cfg[0]) begin
               m_gfx = d[1];
               m_ctrl[0] = 1'b0;
            end
         end
      end
   endtask

   task automatic rd(input string tag, input logic [15:0] a, input logic vr);
      cyc(tag, a, 1'b0, 1'b1, 8'h00, vr);
   endtask

   task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
      cyc(tag, a, 1'b1, 1'b0, d, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0;
      io_wdata = '0; vretrace = 1'b0; crtc_rdata = 8'h5A;
      m_ctrl = 8'h01; m_cfg = '0; m_mode = '0; m_gfx = 1'b0; m_tog = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 reset state and register access
      cyc("R3", 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
      rd("R3", 16'h03CC, 1'b0);
      wr("R3", 16'h03C2, 8'hA5);
      rd("R3", 16'h03CC, 1'b0);
      // R1 colour base active, mono addresses silent
      rd("R1", 16'h03D4, 1'b0);
      crtc_rdata = 8'h3C;
      rd("R1", 16'h03D5, 1'b0);
      wr("R1", 16'h03D4, 8'h11);
      rd("R1", 16'h03B4, 1'b0);
      wr("R1", 16'h03B5, 8'h22);
      // R4 inactive status address gives no clear
      rd("R4", 16'h03BA, 1'b0);
      // R6 toggle sequence, R4 clear pulse
      rd("R6", 16'h03DA, 1'b0);
      rd("R6", 16'h03DA, 1'b0);
      rd("R5", 16'h03DA, 1'b1);
      rd("R6", 16'h03DA, 1'b0);
      // R2 mono base
      wr("R2", 16'h03C2, 8'h00);
      rd("R2", 16'h03B4, 1'b0);
      rd("R2", 16'h03D4, 1'b0);
      rd("R2", 16'h03DA, 1'b0);
      rd("R4", 16'h03BA, 1'b0);
      rd("R5", 16'h03BA, 1'b1);
      // R8 gated mode write
      wr("R8", 16'h03B8, 8'h82);
      rd("R9", 16'h03B8, 1'b0);
      // R7 feature enable
      wr("R7", 16'h03BF, 8'h03);
      rd("R7", 16'h03BF, 1'b0);
      // R10 switch forces mono base
      wr("R10", 16'h03C2, 8'h41);
      wr("R10", 16'h03B8, 8'h82);
      rd("R10", 16'h03CC, 1'b0);
      rd("R5", 16'h03BA, 1'b1);
      wr("R5", 16'h03C2, 8'h01);
      rd("R5", 16'h03DA, 1'b1);
      // R9 page with enable bit 1 only
      wr("R8", 16'h03B8, 8'h00);
      wr("R9", 16'h03BF, 8'h02);
      wr("R9", 16'h03B8, 8'h82);
      rd("R9", 16'h03CC, 1'b0);
      wr("R9", 16'h03BF, 8'h00);
      // R11 unmapped and write-only ports
      rd("R11", 16'h03C0, 1'b0);
      rd("R11", 16'h03C2, 1'b0);
      rd("R11", 16'h13D4, 1'b0);
      cyc("R11", 16'h03CC, 1'b0, 1'b0, 8'h00, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule